// File: doc/BRIEF.md
# Self-Checking Syndrome Unit for a 16+8 Latin-Square Code

This unit sits on the read path of a memory protected by a single-error-correcting orthogonal Latin square code. Each word holds 16 data bits, seen as a 4x4 grid, and 8 stored check bits. The first four check bits cover the rows of the grid and the last four cover its columns. The unit computes each check bit again from the data and XORs it with the stored copy to form an 8-bit syndrome. A later majority-vote and correction stage takes the syndrome; that stage lies outside this block.

In the same cycle the unit checks its own logic. It forms two single-bit parities:
- `r1_q` is the parity of all syndrome bits.
- `r2_q` is the parity of the stored check bits alone.

Every data bit feeds exactly two check equations, so the recomputed checks always have even total parity. A healthy unit therefore always gives `r1_q == r2_q`. The two parities come from separate XOR networks that share no gate. Each syndrome bit also has its own XOR network. As a result, a fault on any one internal node flips only one of the compared values, and `error_flag_q` goes high.

A fault-injection mask lets a test flip chosen syndrome nodes, to show that the self-check responds. All outputs are registered and appear one clock after the inputs are sampled. The block has no state sequencing. Its only states are reset, in which the registers are cleared, and run, in which they load every cycle.

Top module: `ols_syndrome_sc`

## Requirements
- R1: While `rst_n` is low, `syndrome_q`, `r1_q`, `r2_q` and `error_flag_q` are all 0.
- R2: For data bit index p = 4*row + col, check bit `row` (0..3) is the XOR of the data bits in that row. Check bit `4+col` (4..7) is the XOR of the data bits in that column. Syndrome bit i is recomputed check i XOR `check_in[i]`.
- R3: A word whose stored checks match its data gives an all-zero syndrome, and `error_flag_q` is 0.
- R4: A single flipped data bit at index p sets exactly syndrome bits p/4 and 4+(p mod 4), with `r1_q == r2_q`.
- R5: A single flipped stored check bit i sets exactly syndrome bit i, with `r1_q == r2_q`.
- R6: `r2_q` is the parity of the sampled `check_in`. `r1_q` is the parity of `syndrome_q`. With `fault_inj` at 0 the two are equal for any input.
- R7: `fault_inj[i]` flips syndrome bit i. A mask with one bit set drives `error_flag_q` high, where `error_flag_q` equals `r1_q XOR r2_q`.
- R8: Outputs show the inputs sampled at the previous rising clock edge, a latency of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | 16 | Data bits read from memory, index 4*row+col |
| check_in | input | 8 | Stored check bits: rows in 0..3, columns in 4..7 |
| fault_inj | input | 8 | Test mask XORed onto the syndrome nodes |
| syndrome_q | output | 8 | Registered syndrome |
| r1_q | output | 1 | Registered parity of the syndrome |
| r2_q | output | 1 | Registered parity of the stored check bits |
| error_flag_q | output | 1 | Registered disagreement of r1 and r2 |

## Verification
Any wrong internal node in a syndrome network changes exactly one syndrome bit. That change appears at the ports one clock after the word is sampled, as an odd syndrome parity and a raised `error_flag_q`. A wrong row or column equation shows up as the wrong syndrome pair for a single-bit data error. The bench therefore walks every data position and every check position. A fault confined to the stored-parity network flips `r2_q` alone on the next clock. Two flipped syndrome nodes cancel in the parity and stay hidden, which the bench demonstrates directly.

// File: rtl/ols_syn_pkg.sv
package ols_syn_pkg;

    localparam int unsigned SIDE_DEFAULT = 4;

    // Membership of data bit dbit in check equation chk for a side x side grid.
    // Equations 0..side-1 are rows, side..2*side-1 are columns.
    function automatic bit covers(input int unsigned side,
                                  input int unsigned chk,
                                  input int unsigned dbit);
        if (chk < side)
            return (dbit / side) == chk;
        else
            return (dbit % side) == (chk - side);
    endfunction

endpackage

// File: rtl/ols_check_gen.sv
module ols_check_gen #(
    parameter int unsigned SIDE = 4
) (
    input  logic [SIDE*SIDE-1:0] data_i,
    output logic [2*SIDE-1:0]    chk_o
);
    localparam int unsigned KW = SIDE * SIDE;
    localparam int unsigned CW = 2 * SIDE;

    // One separate network per check bit: no gate shared between them.
    for (genvar g = 0; g < CW; g++) begin : g_eq
        logic acc;
        always_comb begin
            acc = 1'b0;
            for (int unsigned b = 0; b < KW; b++) begin
                if (ols_syn_pkg::covers(SIDE, g, b))
                    acc = acc ^ data_i[b];
            end
        end
        assign chk_o[g] = acc;
    end
endmodule

// File: rtl/ols_syn_xor.sv
module ols_syn_xor #(
    parameter int unsigned CW = 8
) (
    input  logic [CW-1:0] recomp_i,
    input  logic [CW-1:0] stored_i,
    input  logic [CW-1:0] inj_i,
    output logic [CW-1:0] syn_o
);
    for (genvar i = 0; i < CW; i++) begin : g_bit
        assign syn_o[i] = recomp_i[i] ^ stored_i[i] ^ inj_i[i];
    end
endmodule

// File: rtl/ols_parity_tree.sv
module ols_parity_tree #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] vec_i,
    output logic         par_o
);
    always_comb begin
        par_o = 1'b0;
        for (int unsigned i = 0; i < W; i++)
            par_o = par_o ^ vec_i[i];
    end
endmodule

// File: rtl/ols_syndrome_sc.sv
module ols_syndrome_sc #(
    parameter int unsigned SIDE = ols_syn_pkg::SIDE_DEFAULT
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SIDE*SIDE-1:0]   data_in,
    input  logic [2*SIDE-1:0]      check_in,
    input  logic [2*SIDE-1:0]      fault_inj,
    output logic [2*SIDE-1:0]      syndrome_q,
    output logic                   r1_q,
    output logic                   r2_q,
    output logic                   error_flag_q
);
    localparam int unsigned KW = SIDE * SIDE;
    localparam int unsigned CW = 2 * SIDE;

    logic [CW-1:0] recomp;
    logic [CW-1:0] syn_c;
    logic          r1_c;
    logic          r2_c;

    ols_check_gen #(.SIDE(SIDE)) u_gen (
        .data_i (data_in),
        .chk_o  (recomp)
    );

    ols_syn_xor #(.CW(CW)) u_syn (
        .recomp_i (recomp),
        .stored_i (check_in),
        .inj_i    (fault_inj),
        .syn_o    (syn_c)
    );

    // r1 is built from the syndrome nodes only.
    ols_parity_tree #(.W(CW)) u_par_syn (
        .vec_i (syn_c),
        .par_o (r1_c)
    );

    // r2 is built from the stored check bits only, a disjoint network.
    ols_parity_tree #(.W(CW)) u_par_chk (
        .vec_i (check_in),
        .par_o (r2_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            syndrome_q   <= '0;
            r1_q         <= 1'b0;
            r2_q         <= 1'b0;
            error_flag_q <= 1'b0;
        end else begin
            syndrome_q   <= syn_c;
            r1_q         <= r1_c;
            r2_q         <= r2_c;
            error_flag_q <= r1_c ^ r2_c;
        end
    end

    // The data width is fixed by the grid side.
    if (KW != SIDE * SIDE) begin : g_bad
        $error("grid width mismatch");
    end
endmodule

// File: rtl/ols_syndrome_sc_chk.sv
module ols_syndrome_sc_chk #(
    parameter int unsigned SIDE = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [SIDE*SIDE-1:0] data_in,
    input logic [2*SIDE-1:0]    check_in,
    input logic [2*SIDE-1:0]    fault_inj,
    input logic [2*SIDE-1:0]    syndrome_q,
    input logic                 r1_q,
    input logic                 r2_q,
    input logic                 error_flag_q
);
    // R1: reset clears every output
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (syndrome_q == '0 && !r1_q && !r2_q && !error_flag_q));

    // R6: r2 follows the parity of the stored checks one cycle later
    p_stored_parity_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (r2_q == ^$past(check_in)));

    // R6: without injection the syndrome parity equals the stored parity
    p_agree_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_inj == '0) |=> (r1_q == r2_q && ^syndrome_q == r2_q));

    // R7: a single injected node fault is always flagged
    p_inject_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(fault_inj) == 1) |=> error_flag_q);

    // R8: steady inputs give steady outputs
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(data_in) && $stable(check_in) && $stable(fault_inj) && $past(rst_n))
        |=> $stable(syndrome_q));
endmodule

bind ols_syndrome_sc ols_syndrome_sc_chk #(.SIDE(SIDE)) u_chk (.*);

// File: tb/ols_syndrome_sc_test.sv
module ols_syndrome_sc_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] data_in = '0;
    logic [7:0]  check_in = '0;
    logic [7:0]  fault_inj = '0;
    logic [7:0]  syndrome_q;
    logic        r1_q, r2_q, error_flag_q;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;  // 50 MHz

    ols_syndrome_sc uut (
        .clk(clk), .rst_n(rst_n), .data_in(data_in), .check_in(check_in),
        .fault_inj(fault_inj), .syndrome_q(syndrome_q), .r1_q(r1_q),
        .r2_q(r2_q), .error_flag_q(error_flag_q)
    );

    // Independent encoder: rows then columns of a 4x4 grid.
    function automatic logic [7:0] enc(input logic [15:0] d);
        logic [7:0] c = '0;
        for (int r = 0; r < 4; r++)
            for (int k = 0; k < 4; k++) begin
                c[r]   = c[r]   ^ d[r*4+k];
                c[4+k] = c[4+k] ^ d[r*4+k];
            end
        return c;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [15:0] d, input logic [7:0] c, input logic [7:0] m);
        @(negedge clk);
        data_in = d; check_in = c; fault_inj = m;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 syndrome", syndrome_q, 0);
        check("R1 flags", {r1_q, r2_q, error_flag_q}, 0);
    endtask

    task automatic t_clean;
        logic [15:0] pats [4] = '{16'h0000, 16'hFFFF, 16'hA5C3, 16'h1234};
        foreach (pats[i]) begin
            apply(pats[i], enc(pats[i]), 8'h00);
            check("R3 zero syndrome", syndrome_q, 0);
            check("R3 flag low", error_flag_q, 0);
            check("R6 r2 parity", r2_q, ^enc(pats[i]));
        end
        // R2: syndrome equals recomputed XOR stored for arbitrary stored bits
        apply(16'h3C5A, 8'h96, 8'h00);
        check("R2 syndrome formula", syndrome_q, enc(16'h3C5A) ^ 8'h96);
        check("R6 r1 equals r2", r1_q, r2_q);
    endtask

    task automatic t_data_err;
        logic [15:0] base = 16'hB71E;
        for (int p = 0; p < 16; p++) begin
            logic [7:0] exp;
            exp = '0;
            exp[p/4] = 1'b1;
            exp[4 + p%4] = 1'b1;
            apply(base ^ (16'h1 << p), enc(base), 8'h00);
            check("R4 data error syndrome", syndrome_q, exp);
            check("R4 r1 equals r2", {r1_q, error_flag_q}, {r2_q, 1'b0});
        end
    endtask

    task automatic t_check_err;
        logic [15:0] base = 16'h0F0F;
        for (int i = 0; i < 8; i++) begin
            apply(base, enc(base) ^ (8'h1 << i), 8'h00);
            check("R5 check error syndrome", syndrome_q, 8'h1 << i);
            check("R5 flag low", error_flag_q, 0);
        end
    endtask

    task automatic t_inject;
        logic [15:0] base = 16'hC0DE;
        for (int i = 0; i < 8; i++) begin
            apply(base, enc(base), 8'h1 << i);
            check("R7 injected bit", syndrome_q, 8'h1 << i);
            check("R7 flag high", error_flag_q, 1);
            check("R7 r1 differs", r1_q ^ r2_q, 1);
        end
        apply(base, enc(base), 8'h05);
        check("R7 double injection masked", error_flag_q, 0);
    endtask

    task automatic t_latency;
        @(negedge clk);
        data_in = 16'h0001; check_in = enc(16'h0000); fault_inj = 0;
        @(posedge clk);
        @(negedge clk);
        data_in = 16'h0000;  // change after the sampling edge
        check("R8 first word visible", syndrome_q, 8'h11);
        @(posedge clk);
        @(negedge clk);
        check("R8 second word visible", syndrome_q, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_clean();
        t_data_err();
        t_check_err();
        t_inject();
        t_latency();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 reset clears", {syndrome_q, r1_q, r2_q, error_flag_q}, 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule